// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with Result Pair

This block runs integer multiplication and division over several clock cycles, one operand bit per cycle, and keeps each result in a dedicated pair of result registers. The upper register (HI) and the lower register (LO) are driven continuously to read ports. A client reads them the same way a processor moves data out of a high or a low result register.

A client places two operands and an operation code on the inputs and pulses `start_i` while the unit is idle. The unit raises `busy_o` for exactly `WIDTH` cycles and then writes both result registers in the same edge that drops `busy_o`.

A product fills HI with its upper half and LO with its lower half. A division puts the quotient in LO and the remainder in HI. No operation reports overflow. A caller that needs to know whether a product fits in one word inspects HI itself.

Top module: `md_unit`

## Requirements
- R1: After reset, `busy_o` is low and `hi_o` and `lo_o` are zero.
- R2: `op_i` selects the operation: 2'b00 is signed multiply, 2'b01 is unsigned multiply, 2'b10 is signed divide and 2'b11 is unsigned divide. A start is accepted only when `busy_o` is low, and `busy_o` rises only after an accepted start.
- R3: A multiply forms the full 2·WIDTH-bit product, with operands read as two's complement or as unsigned according to `op_i`. HI receives the upper WIDTH bits and LO the lower WIDTH bits; for example, unsigned 8 × 9 leaves HI = 0 and LO = 72.
- R4: A divide with a nonzero divisor puts the quotient in LO and the remainder in HI, so that dividend = quotient × divisor + remainder. A signed quotient truncates toward zero, and a signed remainder carries the sign of the dividend; for example, −7 / 2 gives LO = −3 and HI = −1.
- R5: No overflow is detected or corrected. A signed divide of the most negative value by −1 leaves LO equal to the most negative value and HI = 0.
- R6: A divide by zero, signed or unsigned, leaves LO all ones and HI equal to the dividend, and raises no flag.
- R7: `busy_o` stays high for exactly WIDTH cycles, starting in the cycle after an accepted start. The new HI/LO values appear in the first cycle in which `busy_o` is low again.
- R8: HI and LO keep their previous values in every cycle in which `busy_o` is high.
- R9: A start pulse while `busy_o` is high is ignored: the running operation and its result are unchanged, and no new operation follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| op_i | input | 2 | Operation code (see R2) |
| opa_i | input | WIDTH | Multiplicand or dividend |
| opb_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| hi_o | output | WIDTH | HI register: upper product half or remainder |
| lo_o | output | WIDTH | LO register: lower product half or quotient |

## Verification
The assertions check the following on every cycle:
- the busy window is exactly WIDTH cycles long;
- HI and LO stay frozen while the unit is busy;
- busy rises only after an accepted start;
- a divide by zero ends with LO all ones;
- every unsigned divide satisfies the quotient-remainder identity with a remainder smaller than the divisor.

Only the bench's scenarios can show that signed products, signed quotients, the signs of remainders and the truncation at the most negative value match the arithmetic. The bench covers these with an exhaustive sweep of a 4-bit instance and with directed 32-bit corner cases.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    MD_MUL  = 2'b00,
    MD_MULU = 2'b01,
    MD_DIV  = 2'b10,
    MD_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/md_prep.sv
// Operand conditioning: magnitudes and result sign flags.
module md_prep #(
  parameter int WIDTH = 32
) (
  input  md_pkg::md_op_e   op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             is_div_o,
  output logic             is_signed_o,
  output logic [WIDTH-1:0] mag_a_o,
  output logic [WIDTH-1:0] mag_b_o,
  output logic             neg_main_o,
  output logic             neg_rem_o,
  output logic             div_zero_o
);
  logic neg_a, neg_b;

  always_comb begin
    is_div_o    = (op_i == md_pkg::MD_DIV) || (op_i == md_pkg::MD_DIVU);
    is_signed_o = (op_i == md_pkg::MD_DIV) || (op_i == md_pkg::MD_MUL);
    neg_a       = is_signed_o && a_i[WIDTH-1];
    neg_b       = is_signed_o && b_i[WIDTH-1];
    mag_a_o     = neg_a ? -a_i : a_i;
    mag_b_o     = neg_b ? -b_i : b_i;
    neg_main_o  = neg_a ^ neg_b;
    neg_rem_o   = neg_a;
    div_zero_o  = (b_i == '0);
  end
endmodule

// File: rtl/md_step.sv
// One radix-2 iteration: shift-add multiply or restoring divide.
module md_step #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic [WIDTH-1:0] acc_hi_i,
  input  logic [WIDTH-1:0] acc_lo_i,
  input  logic [WIDTH-1:0] opnd_i,
  output logic [WIDTH-1:0] nxt_hi_o,
  output logic [WIDTH-1:0] nxt_lo_o
);
  logic [WIDTH:0]   sum;
  logic [WIDTH:0]   sh;
  logic [WIDTH-1:0] sub;
  logic             ge;

  always_comb begin
    sum = {1'b0, acc_hi_i} + (acc_lo_i[0] ? {1'b0, opnd_i} : '0);
    sh  = {acc_hi_i, acc_lo_i[WIDTH-1]};
    sub = sh[WIDTH-1:0] - opnd_i;   // true difference < 2^WIDTH when ge
    ge  = (sh >= {1'b0, opnd_i});
    if (is_div_i) begin
      nxt_hi_o = ge ? sub : sh[WIDTH-1:0];
      nxt_lo_o = {acc_lo_i[WIDTH-2:0], ge};
    end else begin
      nxt_hi_o = sum[WIDTH:1];
      nxt_lo_o = {sum[0], acc_lo_i[WIDTH-1:1]};
    end
  end
endmodule

// File: rtl/md_fix.sv
// Sign restoration of the raw magnitude result.
module md_fix #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic             neg_main_i,
  input  logic             neg_rem_i,
  input  logic             div_zero_i,
  input  logic [WIDTH-1:0] raw_hi_i,
  input  logic [WIDTH-1:0] raw_lo_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int W2 = 2 * WIDTH;
  logic [W2-1:0] prod;

  always_comb begin
    prod = {raw_hi_i, raw_lo_i};
    if (neg_main_i) prod = -prod;
    if (is_div_i) begin
      lo_o = (neg_main_i && !div_zero_i) ? -raw_lo_i : raw_lo_i;
      hi_o = neg_rem_i ? -raw_hi_i : raw_hi_i;
    end else begin
      hi_o = prod[W2-1:WIDTH];
      lo_o = prod[WIDTH-1:0];
    end
  end
endmodule

// File: rtl/md_unit.sv
module md_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam int RW = $clog2(WIDTH + 1) + 1;
  localparam int W2 = 2 * WIDTH;

  md_pkg::md_op_e op_e;
  assign op_e = md_pkg::md_op_e'(op_i);

  logic             p_is_div, p_signed, p_neg_main, p_neg_rem, p_dz;
  logic [WIDTH-1:0] p_mag_a, p_mag_b;

  md_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i(op_e), .a_i(opa_i), .b_i(opb_i),
    .is_div_o(p_is_div), .is_signed_o(p_signed),
    .mag_a_o(p_mag_a), .mag_b_o(p_mag_b),
    .neg_main_o(p_neg_main), .neg_rem_o(p_neg_rem), .div_zero_o(p_dz)
  );

  logic             busy_q, is_div_q, signed_q, neg_main_q, neg_rem_q, dz_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] acc_hi_q, acc_lo_q, opnd_q, hi_q, lo_q;
  logic [WIDTH-1:0] src_a_q, src_b_q;
  logic [WIDTH-1:0] nxt_hi, nxt_lo, fix_hi, fix_lo;

  md_step #(.WIDTH(WIDTH)) u_step (
    .is_div_i(is_div_q), .acc_hi_i(acc_hi_q), .acc_lo_i(acc_lo_q),
    .opnd_i(opnd_q), .nxt_hi_o(nxt_hi), .nxt_lo_o(nxt_lo)
  );

  md_fix #(.WIDTH(WIDTH)) u_fix (
    .is_div_i(is_div_q), .neg_main_i(neg_main_q), .neg_rem_i(neg_rem_q),
    .div_zero_i(dz_q), .raw_hi_i(nxt_hi), .raw_lo_i(nxt_lo),
    .hi_o(fix_hi), .lo_o(fix_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      acc_hi_q   <= '0;
      acc_lo_q   <= '0;
      opnd_q     <= '0;
      is_div_q   <= 1'b0;
      signed_q   <= 1'b0;
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      dz_q       <= 1'b0;
      src_a_q    <= '0;
      src_b_q    <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q     <= 1'b1;
        cnt_q      <= CW'(WIDTH - 1);
        acc_hi_q   <= '0;
        acc_lo_q   <= p_is_div ? p_mag_a : p_mag_b;
        opnd_q     <= p_is_div ? p_mag_b : p_mag_a;
        is_div_q   <= p_is_div;
        signed_q   <= p_signed;
        neg_main_q <= p_neg_main;
        neg_rem_q  <= p_neg_rem;
        dz_q       <= p_dz;
        src_a_q    <= opa_i;
        src_b_q    <= opb_i;
      end
    end else begin
      acc_hi_q <= nxt_hi;
      acc_lo_q <= nxt_lo;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        hi_q   <= fix_hi;
        lo_q   <= fix_lo;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // Independent busy run-length counter for the checks below.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r7_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == RW'(WIDTH));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(hi_o) && $stable(lo_o)));

  a_r2_start_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));

  a_r6_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && is_div_q && dz_q) |-> (lo_o == '1));

  a_r4_divu_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && is_div_q && !signed_q && !dz_q) |->
      ((W2'(lo_o) * W2'(src_b_q) + W2'(hi_o) == W2'(src_a_q)) && (hi_o < src_b_q)));
endmodule

// File: tb/md_unit_tb_top.sv
module md_unit_tb_top;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        w_start = 0, s_start = 0;
  logic [1:0]  w_op = 0, s_op = 0;
  logic [31:0] w_a = 0, w_b = 0, w_hi, w_lo;
  logic [SW-1:0] s_a = 0, s_b = 0, s_hi, s_lo;
  logic        w_busy, s_busy;

  md_unit #(.WIDTH(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(w_start), .op_i(w_op),
    .opa_i(w_a), .opb_i(w_b), .busy_o(w_busy), .hi_o(w_hi), .lo_o(w_lo));

  md_unit #(.WIDTH(SW)) dut_s (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .op_i(s_op),
    .opa_i(s_a), .opb_i(s_b), .busy_o(s_busy), .hi_o(s_hi), .lo_o(s_lo));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic longint sext(input int w, input logic [63:0] v);
    if (v[w-1]) return longint'(v) - (longint'(1) << w);
    return longint'(v);
  endfunction

  function automatic void model(input int w, input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] hi, output logic [63:0] lo);
    logic [63:0] mask, p;
    longint sa, sb;
    mask = (64'd1 << w) - 1;
    sa = sext(w, a);
    sb = sext(w, b);
    hi = 0;
    lo = 0;
    case (op)
      2'b00: begin p = 64'(sa * sb); hi = (p >> w) & mask; lo = p & mask; end
      2'b01: begin p = a * b; hi = (p >> w) & mask; lo = p & mask; end
      2'b10: if (b == 0) begin lo = mask; hi = a; end
             else begin lo = 64'(sa / sb) & mask; hi = 64'(sa % sb) & mask; end
      default: if (b == 0) begin lo = mask; hi = a; end
               else begin lo = a / b; hi = a % b; end
    endcase
  endfunction

  // sm selects the 4-bit instance; req overrides the auto-chosen tag.
  task automatic run_op(input bit sm, input logic [1:0] op, input logic [63:0] a, input logic [63:0] b, input string req);
    int w, run;
    logic [63:0] eh, el, h0, l0, mask;
    bit hold_ok;
    string tag;
    w = sm ? SW : 32;
    mask = (64'd1 << w) - 1;
    model(w, op, a, b, eh, el);
    tag = req;
    if (tag == "") begin
      if (op[1] && b == 0) tag = "R6";
      else if (op == 2'b10 && a == (64'd1 << (w-1)) && b == mask) tag = "R5";
      else if (op[1]) tag = "R4";
      else tag = "R3";
    end
    @(negedge clk);
    if (sm) begin s_op = op; s_a = a[SW-1:0]; s_b = b[SW-1:0]; s_start = 1; h0 = 64'(s_hi); l0 = 64'(s_lo); end
    else    begin w_op = op; w_a = a[31:0]; w_b = b[31:0]; w_start = 1; h0 = 64'(w_hi); l0 = 64'(w_lo); end
    @(negedge clk);
    s_start = 0;
    w_start = 0;
    run = 0;
    hold_ok = 1;
    while ((sm ? s_busy : w_busy) && run < 100) begin
      run++;
      if (sm ? (64'(s_hi) != h0 || 64'(s_lo) != l0) : (64'(w_hi) != h0 || 64'(w_lo) != l0)) hold_ok = 0;
      @(negedge clk);
    end
    chk("R7", "busy cycles", 64'(run), 64'(w));
    chk("R8", "hold while busy", 64'(hold_ok), 64'd1);
    chk(tag, $sformatf("HI op=%0d a=%h b=%h", op, a, b), sm ? 64'(s_hi) : 64'(w_hi), eh);
    chk(tag, $sformatf("LO op=%0d a=%h b=%h", op, a, b), sm ? 64'(s_lo) : 64'(w_lo), el);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 64'(w_busy), 0);
    chk("R1", "hi", 64'(w_hi), 0);
    chk("R1", "lo", 64'(w_lo), 0);
    rst_n = 1;
    @(negedge clk);

    // Directed 32-bit cases
    run_op(0, 2'b01, 8, 9, "R3");
    run_op(0, 2'b00, 64'hFFFF_FFFD, 7, "");
    run_op(0, 2'b00, 64'h8000_0000, 64'h8000_0000, "");
    run_op(0, 2'b01, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "");
    run_op(0, 2'b00, 64'hFFFF_FFFF, 2, "R2");  // signed: -2
    run_op(0, 2'b01, 64'hFFFF_FFFF, 2, "R2");  // unsigned: HI=1
    run_op(0, 2'b10, 64'hFFFF_FFF9, 2, "R4");  // -7/2
    run_op(0, 2'b10, 7, 64'hFFFF_FFFE, "R4");  // 7/-2
    run_op(0, 2'b11, 64'hFFFF_FFF9, 2, "R2");  // unsigned divide of same bits
    run_op(0, 2'b11, 100, 7, "R4");
    run_op(0, 2'b11, 64'hFFFF_FFFF, 1, "R4");
    run_op(0, 2'b10, 64'h8000_0000, 64'hFFFF_FFFF, "R5");
    run_op(0, 2'b10, 64'hFFFF_FFFB, 0, "R6");
    run_op(0, 2'b11, 9, 0, "R6");

    // R9: start while busy is ignored
    @(negedge clk);
    w_op = 2'b01; w_a = 3; w_b = 5; w_start = 1;
    @(negedge clk);
    w_start = 0;
    repeat (4) @(negedge clk);
    w_op = 2'b11; w_a = 100; w_b = 7; w_start = 1;
    @(negedge clk);
    w_start = 0;
    for (int i = 0; i < 40 && w_busy; i++) @(negedge clk);
    chk("R9", "busy after run", 64'(w_busy), 0);
    chk("R9", "HI of first op", 64'(w_hi), 0);
    chk("R9", "LO of first op", 64'(w_lo), 15);
    @(negedge clk);
    chk("R9", "no restart", 64'(w_busy), 0);

    // Exhaustive sweep of the 4-bit instance, all op codes (R2..R6)
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_op(1, 2'(op), 64'(a), 64'(b), "");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule